// File: doc/BRIEF.md
# Fetch-Stage Branch Predictor with Target Buffer

This block sits beside instruction fetch and guesses, from the fetch address alone, whether a branch at that address will be taken and where it will go. It holds two direct-mapped structures. The first is a table of 2-bit saturating counters. The second is a small target buffer that holds a valid bit, an address tag and a target address in each entry. Both are indexed by low bits of the fetch address. The lookup is purely combinational from the stored state: the predicted next address appears in the same cycle as the fetch address.

When a branch resolves in the back end, the update port reports its address, its actual outcome and its actual target. The counter for that address steps one state toward the outcome. A taken branch also writes its target into the buffer, which replaces whatever that entry held. A branch that has never been seen taken has no buffer entry, so it is always predicted not taken and pays the redirect penalty once.

Each counter is a four-state machine with the states CTR_SNT (00), CTR_WNT (01), CTR_WT (10) and CTR_ST (11). A taken outcome follows the transitions SNT→WNT→WT→ST→ST. A not-taken outcome follows ST→WT→WNT→SNT→SNT. Reset places every counter in CTR_WNT.

Top module: `bpred_unit`

## Requirements
- R1: After reset every counter holds 01 and every buffer entry is invalid, so every lookup gives pred_taken=0, pred_hit=0 and pred_target=fetch_pc+4.
- R2: The counter is selected by fetch_pc[7:2]. A counter of 10 or 11 votes taken and a counter of 00 or 01 votes not taken.
- R3: On an update, a taken outcome raises the counter at upd_pc[7:2] by one step, saturating at 11. A not-taken outcome lowers it by one step, saturating at 00.
- R4: The buffer entry is selected by address bits [5:2]. An update with upd_taken=1 makes that entry valid and stores its tag and upd_target. An update with upd_taken=0 leaves the buffer unchanged.
- R5: pred_hit is 1 exactly when the selected entry is valid and its tag matches all of fetch_pc outside bits [5:2].
- R6: pred_taken is 1 only when pred_hit is 1 and the counter votes taken. In that case pred_target is the stored target; otherwise pred_target is fetch_pc+4.
- R7: Two addresses that share buffer index bits but differ in their tag do not alias. A lookup of one misses while the entry holds the other, and a taken update of one evicts the other.
- R8: When a lookup and an update address the same entries in the same cycle, the lookup returns the state from before the update. The update becomes visible from the next cycle.
- R9: While upd_valid is 0, no counter or buffer entry changes, whatever the other update inputs carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fetch_pc | input | 32 | Lookup address |
| pred_taken | output | 1 | Predicted taken |
| pred_hit | output | 1 | Target buffer holds an entry for fetch_pc |
| pred_target | output | 32 | Predicted next fetch address |
| upd_valid | input | 1 | A resolved branch is being reported |
| upd_pc | input | 32 | Address of the resolved branch |
| upd_taken | input | 1 | Actual outcome |
| upd_target | input | 32 | Actual target of the resolved branch |

## Verification
The bench builds the block with its default sizes: 64 counters, 16 buffer entries and 4-byte instruction spacing. Its random phase draws addresses from a 1 KiB window. With that window, every counter is shared by four branch addresses and every buffer entry is contested by sixteen tags, so eviction, counter sharing and saturation at both ends all occur often. Directed sequences then drive one counter through every state, both saturation points, a same-cycle read and write, and an eviction by a conflicting tag.

// File: rtl/bpred_pkg.sv
`timescale 1ns/1ps
package bpred_pkg;

    typedef enum logic [1:0] {
        CTR_SNT = 2'b00,
        CTR_WNT = 2'b01,
        CTR_WT  = 2'b10,
        CTR_ST  = 2'b11
    } ctr_state_e;

    // Transition function of one saturating counter
    function automatic ctr_state_e ctr_next(input ctr_state_e cur, input logic taken);
        ctr_state_e nxt;
        nxt = cur;
        unique case (cur)
            CTR_SNT: nxt = taken ? CTR_WNT : CTR_SNT;
            CTR_WNT: nxt = taken ? CTR_WT  : CTR_SNT;
            CTR_WT:  nxt = taken ? CTR_ST  : CTR_WNT;
            CTR_ST:  nxt = taken ? CTR_ST  : CTR_WT;
        endcase
        return nxt;
    endfunction

    function automatic logic ctr_votes_taken(input ctr_state_e s);
        return (s == CTR_WT) || (s == CTR_ST);
    endfunction

endpackage

// File: rtl/bpred_ctr_table.sv
`timescale 1ns/1ps
module bpred_ctr_table
    import bpred_pkg::*;
#(
    parameter int ENTRIES = 64,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] rd_idx,
    output logic             rd_taken,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic             wr_taken
);

    ctr_state_e ctr_vec [ENTRIES];

    for (genvar g = 0; g < ENTRIES; g++) begin : g_ctr
        ctr_state_e state_q;

        // State register of one counter
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                state_q <= CTR_WNT;
            end else if (wr_en && (wr_idx == IDX_W'(g))) begin
                state_q <= ctr_next(state_q, wr_taken);
            end
        end

        assign ctr_vec[g] = state_q;
    end

    // Output decode
    always_comb begin
        rd_taken = ctr_votes_taken(ctr_vec[rd_idx]);
    end

endmodule

// File: rtl/bpred_tgt_buf.sv
`timescale 1ns/1ps
module bpred_tgt_buf #(
    parameter int ENTRIES = 16,
    parameter int ADDR_W  = 32,
    parameter int LSB     = 2,
    localparam int IDX_W  = $clog2(ENTRIES),
    localparam int TAG_W  = ADDR_W - IDX_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] rd_pc,
    output logic              rd_hit,
    output logic [ADDR_W-1:0] rd_target,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_pc,
    input  logic [ADDR_W-1:0] wr_target
);

    logic [IDX_W-1:0]  rd_idx, wr_idx;
    logic [TAG_W-1:0]  rd_tag, wr_tag;

    assign rd_idx = rd_pc[LSB +: IDX_W];
    assign wr_idx = wr_pc[LSB +: IDX_W];

    // Tag is every address bit outside the index field
    if (LSB > 0) begin : g_tag_split
        assign rd_tag = {rd_pc[ADDR_W-1:LSB+IDX_W], rd_pc[LSB-1:0]};
        assign wr_tag = {wr_pc[ADDR_W-1:LSB+IDX_W], wr_pc[LSB-1:0]};
    end else begin : g_tag_high
        assign rd_tag = rd_pc[ADDR_W-1:IDX_W];
        assign wr_tag = wr_pc[ADDR_W-1:IDX_W];
    end

    logic              val_vec [ENTRIES];
    logic [TAG_W-1:0]  tag_vec [ENTRIES];
    logic [ADDR_W-1:0] tgt_vec [ENTRIES];

    for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
        logic              val_q;
        logic [TAG_W-1:0]  tag_q;
        logic [ADDR_W-1:0] tgt_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                val_q <= 1'b0;
                tag_q <= '0;
                tgt_q <= '0;
            end else if (wr_en && (wr_idx == IDX_W'(g))) begin
                val_q <= 1'b1;
                tag_q <= wr_tag;
                tgt_q <= wr_target;
            end
        end

        assign val_vec[g] = val_q;
        assign tag_vec[g] = tag_q;
        assign tgt_vec[g] = tgt_q;
    end

    always_comb begin
        rd_hit    = val_vec[rd_idx] && (tag_vec[rd_idx] == rd_tag);
        rd_target = tgt_vec[rd_idx];
    end

endmodule

// File: rtl/bpred_unit.sv
`timescale 1ns/1ps
module bpred_unit #(
    parameter int ADDR_W      = 32,
    parameter int CTR_ENTRIES = 64,
    parameter int TGT_ENTRIES = 16,
    parameter int INSN_LSB    = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] fetch_pc,
    output logic              pred_taken,
    output logic              pred_hit,
    output logic [ADDR_W-1:0] pred_target,
    input  logic              upd_valid,
    input  logic [ADDR_W-1:0] upd_pc,
    input  logic              upd_taken,
    input  logic [ADDR_W-1:0] upd_target
);

    localparam int CIDX_W = $clog2(CTR_ENTRIES);
    localparam logic [ADDR_W-1:0] STEP = ADDR_W'(1) << INSN_LSB;

    logic              ctr_taken;
    logic              tb_hit;
    logic [ADDR_W-1:0] tb_target;

    bpred_ctr_table #(
        .ENTRIES (CTR_ENTRIES)
    ) u_ctr (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_idx   (fetch_pc[INSN_LSB +: CIDX_W]),
        .rd_taken (ctr_taken),
        .wr_en    (upd_valid),
        .wr_idx   (upd_pc[INSN_LSB +: CIDX_W]),
        .wr_taken (upd_taken)
    );

    bpred_tgt_buf #(
        .ENTRIES (TGT_ENTRIES),
        .ADDR_W  (ADDR_W),
        .LSB     (INSN_LSB)
    ) u_tgt (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_pc     (fetch_pc),
        .rd_hit    (tb_hit),
        .rd_target (tb_target),
        .wr_en     (upd_valid && upd_taken),
        .wr_pc     (upd_pc),
        .wr_target (upd_target)
    );

    // Redirect only when both the direction and the target are known
    always_comb begin
        pred_hit    = tb_hit;
        pred_taken  = ctr_taken && tb_hit;
        pred_target = pred_taken ? tb_target : (fetch_pc + STEP);
    end

endmodule

// File: rtl/bpred_unit_chk.sv
`timescale 1ns/1ps
module bpred_unit_chk #(
    parameter int ADDR_W   = 32,
    parameter int INSN_LSB = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] fetch_pc,
    input logic              pred_taken,
    input logic              pred_hit,
    input logic [ADDR_W-1:0] pred_target,
    input logic              upd_valid,
    input logic [ADDR_W-1:0] upd_pc,
    input logic              upd_taken,
    input logic [ADDR_W-1:0] upd_target
);

    localparam logic [ADDR_W-1:0] STEP = ADDR_W'(1) << INSN_LSB;

    // R1
    reset_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (!pred_taken && !pred_hit));

    // R6
    taken_needs_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pred_taken |-> pred_hit);

    // R6
    fallthrough_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pred_taken |-> (pred_target == fetch_pc + STEP));

    // R4
    install_visible_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(upd_valid && upd_taken) && (fetch_pc == $past(upd_pc)))
        |-> (pred_hit && (!pred_taken || (pred_target == $past(upd_target)))));

    // R9
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(upd_valid) && $stable(fetch_pc))
        |-> ($stable(pred_taken) && $stable(pred_hit) && $stable(pred_target)));

endmodule

bind bpred_unit bpred_unit_chk #(.ADDR_W(ADDR_W), .INSN_LSB(INSN_LSB)) u_chk (.*);

// File: tb/bpred_unit_test.sv
`timescale 1ns/1ps
module bpred_unit_test;

    localparam time PERIOD = 20ns;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] fetch_pc = '0;
    logic        pred_taken, pred_hit;
    logic [31:0] pred_target;
    logic        upd_valid = 1'b0;
    logic [31:0] upd_pc = '0;
    logic        upd_taken = 1'b0;
    logic [31:0] upd_target = '0;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #(PERIOD/2) clk = ~clk;

    bpred_unit uut (.*);

    // Behavioural reference state
    int          m_cnt [64];
    bit          m_val [16];
    logic [31:0] m_tag [16];
    logic [31:0] m_tgt [16];

    function automatic int cidx(logic [31:0] pc); return int'((pc >> 2) & 32'h3F); endfunction
    function automatic int bidx(logic [31:0] pc); return int'((pc >> 2) & 32'hF);  endfunction
    function automatic logic [31:0] tagof(logic [31:0] pc); return pc & ~32'h3C; endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < 64; i++) m_cnt[i] = 1;
            for (int i = 0; i < 16; i++) begin m_val[i] = 0; m_tag[i] = '0; m_tgt[i] = '0; end
        end else if (upd_valid) begin
            if (upd_taken) begin
                if (m_cnt[cidx(upd_pc)] < 3) m_cnt[cidx(upd_pc)]++;
                m_val[bidx(upd_pc)] = 1;
                m_tag[bidx(upd_pc)] = tagof(upd_pc);
                m_tgt[bidx(upd_pc)] = upd_target;
            end else if (m_cnt[cidx(upd_pc)] > 0) begin
                m_cnt[cidx(upd_pc)]--;
            end
        end
    end

    task automatic check(string rq, string what, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
        end
    endtask

    // Per-cycle comparison against the reference
    always @(negedge clk) begin
        if (rst_n && !done) begin
            bit          e_hit, e_tk;
            logic [31:0] e_tg;
            e_hit = m_val[bidx(fetch_pc)] && (m_tag[bidx(fetch_pc)] == tagof(fetch_pc));
            e_tk  = e_hit && (m_cnt[cidx(fetch_pc)] >= 2);
            e_tg  = e_tk ? m_tgt[bidx(fetch_pc)] : fetch_pc + 32'd4;
            check("R5", "model hit", 32'(pred_hit), 32'(e_hit));
            check("R2,R6", "model taken", 32'(pred_taken), 32'(e_tk));
            check("R6", "model target", pred_target, e_tg);
        end
    end

    task automatic cyc(logic [31:0] pc, logic uv, logic [31:0] up, logic ut, logic [31:0] utg);
        @(posedge clk); #2;
        fetch_pc = pc; upd_valid = uv; upd_pc = up; upd_taken = ut; upd_target = utg;
        @(negedge clk); #1;
    endtask

    task automatic expect_out(string rq, logic t, logic h, logic [31:0] tg);
        check(rq, "taken", 32'(pred_taken), 32'(t));
        check(rq, "hit", 32'(pred_hit), 32'(h));
        check(rq, "target", pred_target, tg);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        #(PERIOD * 200000);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    localparam logic [31:0] PA = 32'h100;
    localparam logic [31:0] PB = 32'h200;

    initial begin
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;

        // R1: empty after reset
        cyc(PA, 0, 0, 0, 0);          expect_out("R1", 0, 0, PA + 4);
        // R8: same-cycle update not yet visible
        cyc(PA, 1, PA, 1, 32'h2000);  expect_out("R8", 0, 0, PA + 4);
        cyc(PA, 0, 0, 0, 0);          expect_out("R4", 1, 1, 32'h2000);
        // counter 10 -> 01 -> 00
        cyc(PA, 1, PA, 0, 0);         expect_out("R3", 1, 1, 32'h2000);
        cyc(PA, 1, PA, 0, 0);         expect_out("R2", 0, 1, PA + 4);
        cyc(PA, 1, PA, 0, 0);         // at 00, stays 00
        cyc(PA, 1, PA, 1, 32'h2000);  // 00 -> 01
        cyc(PA, 0, 0, 0, 0);          expect_out("R3", 0, 1, PA + 4);
        for (int i = 0; i < 4; i++) cyc(PA, 1, PA, 1, 32'h2000);
        cyc(PA, 1, PA, 0, 0);         // 11 -> 10
        cyc(PA, 0, 0, 0, 0);          expect_out("R3", 1, 1, 32'h2000);
        // R9: update inputs ignored without upd_valid
        for (int i = 0; i < 3; i++) cyc(PA, 0, PA, 0, 32'hDEAD0000);
        expect_out("R9", 1, 1, 32'h2000);
        cyc(PA, 0, PA, 1, 32'h5555);
        cyc(PA, 0, 0, 0, 0);          expect_out("R9", 1, 1, 32'h2000);
        // R7: tag conflict at the same entry
        cyc(PB, 0, 0, 0, 0);          expect_out("R7", 0, 0, PB + 4);
        cyc(PB, 1, PB, 1, 32'h3000);
        cyc(PA, 0, 0, 0, 0);          expect_out("R7", 0, 0, PA + 4);
        cyc(PB, 0, 0, 0, 0);          expect_out("R7", 1, 1, 32'h3000);
        // R4: not-taken update keeps the entry
        cyc(PB, 1, PB, 0, 0);
        cyc(PB, 0, 0, 0, 0);          expect_out("R4", 1, 1, 32'h3000);

        // Random phase over a small aliasing window
        for (int i = 0; i < 3000; i++) begin
            logic [31:0] rpc, upc;
            rpc = $urandom & 32'h3FC;
            upc = ($urandom % 2) ? rpc : ($urandom & 32'h3FC);
            cyc(rpc, 1'($urandom % 3 != 0), upc, 1'($urandom % 2), $urandom & 32'hFFFF_FFFC);
        end
        cyc(0, 0, 0, 0, 0);
        finish_run();
    end

endmodule